// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block sits on the host side of a four-wire serial programming link. It drives the target's reset line, the serial clock and the host-to-target data line, and it samples the target-to-host data line. After the host leaves reset it holds the target in reset with the clock low, gives the target a positive reset pulse, waits a settling time, and then shifts out the 32-bit programming-enable word. The target answers by returning the word's second byte while the host sends the third byte. The block compares that byte against the sync value. On a mismatch it pulses reset again and makes another attempt, up to a set number of tries. After that it raises a sticky error.

Once sync is confirmed the block raises `cmd_ready` and `link_up`. A caller then hands it 32-bit commands on a valid/ready pair. Each accepted command is shifted out most significant bit first. The last byte received during that frame comes back on `rsp_data` with a one-cycle `rsp_valid` strobe.

The SCK half period is `HALF_CYC` host cycles. Power-up hold, reset pulse and settling time are `PWRUP_CYC`, `PULSE_CYC` and `SETTLE_CYC`. Attempts are capped by `MAX_TRIES`.

The sequencer has these states:
- ST_POWERUP: reset and SCK low.
- ST_RSTPULSE: reset high.
- ST_SETTLE: reset low, waiting.
- ST_ENABLE: enable frame in flight.
- ST_CHECK: compare the echo.
- ST_READY: idle with the link up.
- ST_XFER: command frame in flight.
- ST_FAIL: attempts exhausted.

The transitions are:
- ST_POWERUP → ST_RSTPULSE when the hold expires.
- ST_RSTPULSE → ST_SETTLE when the pulse expires.
- ST_SETTLE → ST_ENABLE when settling ends; this also starts the frame.
- ST_ENABLE → ST_CHECK when the frame completes.
- ST_CHECK → ST_READY on an echo match.
- ST_CHECK → ST_RSTPULSE on a mismatch with attempts left.
- ST_CHECK → ST_FAIL on a mismatch when the attempt count has reached `MAX_TRIES`.
- ST_READY → ST_XFER on `cmd_valid`.
- ST_XFER → ST_READY when the frame completes.

Top module: `spi_prog_host`

## Requirements
- R1: While `rst_n` is low, and for exactly `PWRUP_CYC` cycles after it rises, `tgt_rst`, `tgt_sck`, `cmd_ready` and `error` are all low.
- R2: Each reset pulse holds `tgt_rst` high for exactly `PULSE_CYC` cycles, and `tgt_sck` is low whenever `tgt_rst` is high.
- R3: The first rising SCK edge of an enable attempt comes exactly `SETTLE_CYC + HALF_CYC` cycles after `tgt_rst` falls. SCK stays low in between.
- R4: The enable frame is the 32-bit word 0xAC530000, sent most significant bit first. `tgt_mosi` is taken by the target at each rising SCK edge and does not change while SCK is high.
- R5: Every SCK high phase and every SCK low phase inside a frame lasts exactly `HALF_CYC` cycles.
- R6: `tgt_miso` is sampled at the end of each low phase. The byte received during frame bits 16 to 23 (the third byte) is compared with 0x53. All 32 bits are shifted whether or not the byte matches.
- R7: On a mismatch another reset pulse and enable attempt follow. After `MAX_TRIES` failed attempts `error` rises and stays high, no further pulses occur, and `cmd_ready` stays low.
- R8: On a match `cmd_ready` and `link_up` go high. A command presented with `cmd_valid` while `cmd_ready` is high is shifted out MSB first, and `cmd_ready` is low until that frame ends.
- R9: After each command frame `rsp_valid` is high for one cycle. `rsp_data` then holds the byte received during frame bits 24 to 31 (the fourth byte).
- R10: `cmd_valid` asserted while `cmd_ready` is low is ignored: it starts no frame and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous host reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_data | input | 32 | Command word, sent MSB first |
| cmd_ready | output | 1 | Sequencer idle with sync confirmed |
| rsp_valid | output | 1 | One-cycle strobe, response byte valid |
| rsp_data | output | 8 | Fourth byte received in the last command frame |
| link_up | output | 1 | Sync confirmed (idle or transferring) |
| error | output | 1 | Enable attempts exhausted, sticky until reset |
| tgt_rst | output | 1 | Target reset, high during a pulse |
| tgt_sck | output | 1 | Serial clock to the target |
| tgt_mosi | output | 1 | Serial data to the target |
| tgt_miso | input | 1 | Serial data from the target |

## Verification
The assertions assume that `cmd_valid` is only meaningful in the idle state and that `tgt_miso` may change at any time. They also assume that `HALF_CYC` is at least 2, so a bit is always stable across the cycle in which SCK rises. The bench models the target as a behavioural shifter. It changes `tgt_miso` only after it sees SCK fall, so every host sample lands on a settled bit. Command words are offered only after `cmd_ready` is observed high, except in one deliberate pulse issued during settling, which checks that an early request is dropped.

// File: rtl/spi_prog_pkg.sv
package spi_prog_pkg;

    localparam int FRAME_BITS = 32;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_RSTPULSE,
        ST_SETTLE,
        ST_ENABLE,
        ST_CHECK,
        ST_READY,
        ST_XFER,
        ST_FAIL
    } seq_state_t;

endpackage

// File: rtl/spi_prog_timer.sv
module spi_prog_timer #(
    parameter int W    = 8,
    parameter int INIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= W'(INIT);
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/spi_prog_shifter.sv
module spi_prog_shifter #(
    parameter int HALF_CYC = 4,
    parameter int FBITS    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [FBITS-1:0] tx_word,
    input  logic             miso,
    output logic             sck,
    output logic             mosi,
    output logic             busy,
    output logic             done,
    output logic [FBITS-1:0] rx_word
);
    localparam int HW = $clog2(HALF_CYC + 1);
    localparam int BW = $clog2(FBITS);

    logic [HW-1:0]    hcnt;
    logic [BW-1:0]    bitn;
    logic [FBITS-1:0] sh;
    logic [FBITS-1:0] rx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            sck  <= 1'b0;
            hcnt <= '0;
            bitn <= '0;
            sh   <= '0;
            rx   <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy <= 1'b1;
                sh   <= tx_word;
                bitn <= '0;
                sck  <= 1'b0;
                hcnt <= HW'(HALF_CYC - 1);
            end else if (busy) begin
                if (hcnt != '0) begin
                    hcnt <= hcnt - 1'b1;
                end else begin
                    hcnt <= HW'(HALF_CYC - 1);
                    if (!sck) begin
                        // end of low phase: rising edge, sample target data
                        sck <= 1'b1;
                        rx  <= {rx[FBITS-2:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bitn == BW'(FBITS - 1)) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            bitn <= bitn + 1'b1;
                            sh   <= {sh[FBITS-2:0], 1'b0};
                        end
                    end
                end
            end
        end
    end

    assign mosi    = sh[FBITS-1];
    assign rx_word = rx;

    // R5: the clock rests low outside a frame
    assert_sck_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    // R4: data line holds still across the high phase
    assert_mosi_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi));

endmodule

// File: rtl/spi_prog_host.sv
module spi_prog_host
    import spi_prog_pkg::*;
#(
    parameter int          HALF_CYC    = 32,
    parameter int          PWRUP_CYC   = 64,
    parameter int          PULSE_CYC   = 16,
    parameter int          SETTLE_CYC  = 2_500_000,
    parameter int          MAX_TRIES   = 4,
    parameter logic [7:0]  SYNC_BYTE   = 8'h53,
    parameter logic [31:0] ENABLE_WORD = 32'hAC53_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [31:0] cmd_data,
    output logic        cmd_ready,
    output logic        rsp_valid,
    output logic [7:0]  rsp_data,
    output logic        link_up,
    output logic        error,
    output logic        tgt_rst,
    output logic        tgt_sck,
    output logic        tgt_mosi,
    input  logic        tgt_miso
);
    localparam int D1   = (PWRUP_CYC > PULSE_CYC) ? PWRUP_CYC : PULSE_CYC;
    localparam int DMAX = (D1 > SETTLE_CYC) ? D1 : SETTLE_CYC;
    localparam int TW   = $clog2(DMAX + 1);
    localparam int TRW  = $clog2(MAX_TRIES + 1);

    seq_state_t state, nxt;

    logic                  tmr_load;
    logic [TW-1:0]         tmr_val;
    logic                  tmr_zero;
    logic                  frm_start;
    logic [FRAME_BITS-1:0] frm_tx;
    logic                  frm_busy;
    logic                  frm_done;
    logic [FRAME_BITS-1:0] frm_rx;
    logic [TRW-1:0]        tries;
    logic                  sync_hit;
    logic                  unused_rx;

    spi_prog_timer #(.W(TW), .INIT(PWRUP_CYC - 1)) tmr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .val  (tmr_val),
        .zero (tmr_zero)
    );

    spi_prog_shifter #(.HALF_CYC(HALF_CYC), .FBITS(FRAME_BITS)) shf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (frm_start),
        .tx_word(frm_tx),
        .miso   (tgt_miso),
        .sck    (tgt_sck),
        .mosi   (tgt_mosi),
        .busy   (frm_busy),
        .done   (frm_done),
        .rx_word(frm_rx)
    );

    assign sync_hit  = (frm_rx[15:8] == SYNC_BYTE);
    assign unused_rx = ^frm_rx[31:16];
    assign frm_tx    = (state == ST_READY) ? cmd_data : ENABLE_WORD;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_POWERUP;
        else
            state <= nxt;
    end

    // next state, timer loads and frame launches
    always_comb begin
        nxt       = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        frm_start = 1'b0;
        unique case (state)
            ST_POWERUP: if (tmr_zero) begin
                nxt      = ST_RSTPULSE;
                tmr_load = 1'b1;
                tmr_val  = TW'(PULSE_CYC - 1);
            end
            ST_RSTPULSE: if (tmr_zero) begin
                nxt      = ST_SETTLE;
                tmr_load = 1'b1;
                tmr_val  = TW'(SETTLE_CYC - 1);
            end
            ST_SETTLE: if (tmr_zero) begin
                nxt       = ST_ENABLE;
                frm_start = 1'b1;
            end
            ST_ENABLE: if (frm_done) nxt = ST_CHECK;
            ST_CHECK: begin
                if (sync_hit) begin
                    nxt = ST_READY;
                end else if (tries >= TRW'(MAX_TRIES)) begin
                    nxt = ST_FAIL;
                end else begin
                    nxt      = ST_RSTPULSE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PULSE_CYC - 1);
                end
            end
            ST_READY: if (cmd_valid) begin
                nxt       = ST_XFER;
                frm_start = 1'b1;
            end
            ST_XFER: if (frm_done) nxt = ST_READY;
            ST_FAIL: nxt = ST_FAIL;
        endcase
    end

    // attempt counter and response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tries     <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            if (state == ST_SETTLE && tmr_zero)
                tries <= tries + 1'b1;
            rsp_valid <= (state == ST_XFER) && frm_done;
            if ((state == ST_XFER) && frm_done)
                rsp_data <= frm_rx[7:0];
        end
    end

    // outputs decoded from state
    always_comb begin
        tgt_rst   = (state == ST_RSTPULSE);
        cmd_ready = (state == ST_READY);
        link_up   = (state == ST_READY) || (state == ST_XFER);
        error     = (state == ST_FAIL);
    end

    assert_rst_sck_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rst |-> !tgt_sck);

    assert_quiet_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |-> (!tgt_sck && !frm_busy));

    assert_check_after_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK) |-> $past(frm_done));

    assert_error_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> (error && !tgt_rst));

    assert_ready_excl_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ready && error));

    assert_ready_idle_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!frm_busy && !tgt_sck));

    assert_rsp_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_no_frame_unready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && !(state == ST_SETTLE)) |=> !$rose(frm_busy) || $past(state == ST_SETTLE));

endmodule

// File: tb/spi_prog_host_tb_top.sv
module spi_prog_host_tb_top;

    localparam int HALF   = 2;
    localparam int PWR    = 5;
    localparam int PULSE  = 4;
    localparam int SETTLE = 30;
    localparam int TRIES  = 3;
    localparam logic [31:0] EN_WORD = 32'hAC53_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_data = '0;
    logic        cmd_ready, rsp_valid, link_up, error;
    logic [7:0]  rsp_data;
    logic        tgt_rst, tgt_sck, tgt_mosi;
    logic        tgt_miso = 1'b0;

    always #4 clk = ~clk;

    spi_prog_host #(
        .HALF_CYC(HALF), .PWRUP_CYC(PWR), .PULSE_CYC(PULSE),
        .SETTLE_CYC(SETTLE), .MAX_TRIES(TRIES)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .link_up(link_up), .error(error), .tgt_rst(tgt_rst), .tgt_sck(tgt_sck),
        .tgt_mosi(tgt_mosi), .tgt_miso(tgt_miso)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural target and timing reference
    logic [31:0] exp_frames[$];
    logic [7:0]  exp_rsp[$];
    int  sync_mode = 0;      // 0: first attempt bad echo, 1: never echo
    int  pulses = 0, frames = 0, rsp_cnt = 0;
    int  pwr_cnt = 0, pulse_len = 0, gap_cnt = 0, ph_len = 0, tbit = 0;
    bit  seen_rst = 0, gap_on = 0;
    logic p_rst = 0, p_sck = 0, p_mosi = 0;
    logic [31:0] tsh = '0;
    logic [7:0]  b1 = '0, b2 = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            pulses = 0; frames = 0; pwr_cnt = 0; pulse_len = 0; gap_cnt = 0;
            ph_len = 0; tbit = 0; seen_rst = 0; gap_on = 0;
            p_rst = 0; p_sck = 0; p_mosi = 0; tgt_miso <= 1'b0;
        end else begin
            if (!seen_rst && !tgt_rst) pwr_cnt++;
            if (tgt_rst) chk(!tgt_sck, "R2 sck low in pulse", tgt_sck, 0);
            if (tgt_rst && !p_rst && !seen_rst) begin
                seen_rst = 1;
                chk(pwr_cnt == PWR, "R1 power-up hold", pwr_cnt, PWR);
            end
            if (tgt_rst) pulse_len++;
            if (!tgt_rst && p_rst) begin
                chk(pulse_len == PULSE, "R2 pulse width", pulse_len, PULSE);
                pulse_len = 0; pulses++; gap_on = 1; gap_cnt = 0; tbit = 0;
            end
            if (gap_on && !tgt_sck) gap_cnt++;
            if (tgt_sck && p_sck) chk(tgt_mosi == p_mosi, "R4 mosi stable high", tgt_mosi, p_mosi);
            if (tgt_sck != p_sck) begin
                if (p_sck || tbit > 0) chk(ph_len == HALF, "R5 phase length", ph_len, HALF);
                ph_len = 1;
            end else begin
                ph_len++;
            end
            if (tgt_sck && !p_sck) begin
                if (gap_on) begin
                    chk(gap_cnt == SETTLE + HALF, "R3 settle gap", gap_cnt, SETTLE + HALF);
                    gap_on = 0;
                end
                tsh = {tsh[30:0], tgt_mosi};
                tbit++;
                if (tbit == 16) b1 = tsh[7:0];
                if (tbit == 24) b2 = tsh[7:0];
                if (tbit == 32) begin
                    logic [31:0] e;
                    e = (exp_frames.size() > 0) ? exp_frames.pop_front() : EN_WORD;
                    chk(tsh == e, "R4/R8 frame word", tsh, e);
                    frames++; tbit = 0;
                end
            end
            if (!tgt_sck && p_sck) begin
                logic [7:0] echo;
                echo = (sync_mode == 0 && pulses >= 2) ? b1 : ~b1;
                if (tbit < 16) tgt_miso <= 1'b0;
                else if (tbit < 24) tgt_miso <= echo[23 - tbit];
                else tgt_miso <= (b1 ^ b2) >> (31 - tbit);
            end
            if (rsp_valid) begin
                logic [7:0] er;
                er = (exp_rsp.size() > 0) ? exp_rsp.pop_front() : 8'hxx;
                chk(rsp_data === er, "R9 response byte", rsp_data, er);
                rsp_cnt++;
            end
            p_rst = tgt_rst; p_sck = tgt_sck; p_mosi = tgt_mosi;
        end
    end

    task automatic send_cmd(input logic [31:0] w);
        int k;
        while (!cmd_ready) @(negedge clk);
        exp_frames.push_back(w);
        exp_rsp.push_back(w[23:16] ^ w[15:8]);
        k = rsp_cnt;
        cmd_data = w; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!cmd_ready && link_up, "R8 ready low in transfer", cmd_ready, 0);
        while (rsp_cnt == k) @(negedge clk);
        @(negedge clk);
        chk(!rsp_valid, "R9 strobe one cycle", rsp_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!tgt_rst && !tgt_sck && !cmd_ready && !error, "R1 reset state",
            {tgt_rst, tgt_sck, cmd_ready, error}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        // early request during settling must be dropped
        while (pulses < 1) @(negedge clk);
        repeat (3) @(negedge clk);
        cmd_data = 32'h1234_5678; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
        chk(pulses == 2, "R7 retry pulse after mismatch", pulses, 2);
        chk(frames == 2, "R6 full frames despite mismatch", frames, 2);
        chk(link_up && !error, "R8 link up after match", {link_up, error}, 2);
        repeat (20) @(negedge clk);
        chk(frames == 2 && rsp_cnt == 0, "R10 early command ignored", frames, 2);
        send_cmd(32'h3012_3400);
        send_cmd(32'hA000_FF55);
        send_cmd(32'h58AA_5500);
        send_cmd(32'hFFFF_FFFF);
        send_cmd(32'h0000_0000);
        chk(rsp_cnt == 5, "R9 response count", rsp_cnt, 5);
        // second run: target never answers correctly
        @(negedge clk); rst_n = 1'b0; sync_mode = 1;
        repeat (3) @(negedge clk);
        @(posedge clk); #1 rst_n = 1'b1;
        while (!error) @(negedge clk);
        chk(pulses == TRIES, "R7 pulse count at error", pulses, TRIES);
        chk(frames == TRIES, "R7 attempts at error", frames, TRIES);
        repeat (50) @(negedge clk);
        chk(error && !cmd_ready && pulses == TRIES, "R7 error sticky", {error, cmd_ready}, 2);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R8 actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule